// File: doc/BRIEF.md
# Colour-Map Palette Register Interface

This block holds the colour map of an 8-bit pseudocolour display: 256 pixel entries, each a 24-bit red/green/blue triple, followed by four overlay entries that a cursor stage uses for its own colours. Software reaches the table through a small 32-bit register window. It first writes an entry number to the index register. It then streams the red, green and blue bytes through a colour port, one byte per access. After the third byte the index moves on to the next entry, so a whole palette can be loaded with one index write followed by a run of colour writes.

Reads walk the same red, green, blue phase and return one byte per access in the top byte of the data word. A second colour port offset sends writes to the overlay bank, where the low two bits of the index pick the entry. A separate lookup port serves the display pipeline. It takes an entry number and returns that entry's 24-bit colour one clock later.

Top module: `cmap_dac`

## Requirements
- R1: A full-width write to byte offset 0 loads the entry index from data bits 31:24 and returns the component phase to red (phase 0).
- R2: Full-width writes to offset 4 store data bits 31:24 into pixel entry `index`. Successive writes fill red (lookup bits 23:16), then green (15:8), then blue (7:0).
- R3: The access that handles the blue component advances the index by one, wrapping from 255 to 0, and returns the phase to red.
- R4: Full-width writes to offset 12 follow the same phase sequence and the same index advance, but store into overlay entry 256 + (index mod 4). The pixel entries are left unchanged.
- R5: A full-width read returns, one cycle later on the read data port, the current component of pixel entry `index` in bits 31:24 with bits 23:0 zero. Each read steps the shared phase, and a read of blue advances the index. A read strobe that arrives together with a write is ignored.
- R6: Writes to any other offset, and any access whose byte enables are not all four set, change neither the table, the index nor the phase.
- R7: After reset, entries 255, 256 and 258 hold 0xFFFFFF. Every other entry holds zero. The index, the phase and the read data are zero.
- R8: The lookup port returns the colour of entry `lut_idx` (0 to 259) on `lut_rgb` on the clock after it is presented. An entry number above 259 returns zero.
- R9: When a colour write and a lookup hit the same entry in one cycle, the lookup returns the value from before the write. The new value appears on the following lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_be | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lut_idx | input | 9 | Lookup entry number |
| lut_rgb | output | 24 | Registered lookup colour {R,G,B} |

## Verification
The bench builds the block with its default parameters: 256 pixel entries, 4 overlay entries, 8-bit components and a 4-bit offset. With these values both boundaries are within reach in a few dozen cycles. The index wrap from 255 to 0 is reached straight after an overlay load, and an entry number above 259 lands in the unused part of the 9-bit lookup range. The 4-entry overlay bank also makes the modulo-4 selection visible, because an index of 255 or 2 lands on overlay entries 259 and 258, which differ at reset.

// File: rtl/cmap_dac.sv
module cmap_dac #(
  parameter int ADDR_W = 4,
  parameter int NPIX   = 256,
  parameter int NOVL   = 4,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_be,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [$clog2(NPIX+NOVL)-1:0] lut_idx,
  output logic [3*CW-1:0]   lut_rgb
);
  localparam int NENT = NPIX + NOVL;
  localparam int IW   = $clog2(NPIX);
  localparam int LW   = $clog2(NENT);
  localparam int OW   = $clog2(NOVL);

  localparam logic [ADDR_W-1:0] OFF_IDX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_PIX = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_OVL = ADDR_W'(12);

  logic [3*CW-1:0] tbl [NENT];
  logic [IW-1:0]   idx;
  logic [1:0]      phase;
  logic [CW-1:0]   cur_comp;
  logic [LW-1:0]   tgt;

  wire full   = (reg_be == 4'hF);
  wire wr_ok  = reg_wr && full;
  wire hit_ix = wr_ok && (reg_addr == OFF_IDX);
  wire hit_px = wr_ok && (reg_addr == OFF_PIX);
  wire hit_ov = wr_ok && (reg_addr == OFF_OVL);
  wire rd_ok  = reg_rd && full && !reg_wr;
  wire step   = hit_px || hit_ov || rd_ok;
  wire [CW-1:0] wbyte = reg_wdata[31 -: CW];

  assign tgt = hit_ov ? LW'(NPIX) + LW'(idx[OW-1:0]) : LW'(idx);

  always_comb begin
    case (phase)
      2'd0:    cur_comp = tbl[LW'(idx)][3*CW-1 -: CW];
      2'd1:    cur_comp = tbl[LW'(idx)][2*CW-1 -: CW];
      default: cur_comp = tbl[LW'(idx)][CW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++)
        tbl[i] <= (i == NPIX-1 || i == NPIX || i == NPIX+2) ? '1 : '0;
    end else if (hit_px || hit_ov) begin
      case (phase)
        2'd0:    tbl[tgt][3*CW-1 -: CW] <= wbyte;
        2'd1:    tbl[tgt][2*CW-1 -: CW] <= wbyte;
        default: tbl[tgt][CW-1:0]       <= wbyte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= 2'd0;
    end else if (hit_ix) begin
      idx   <= reg_wdata[31 -: IW];
      phase <= 2'd0;
    end else if (step) begin
      if (phase == 2'd2) begin
        phase <= 2'd0;
        idx   <= idx + 1'b1;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      lut_rgb   <= '0;
    end else begin
      if (rd_ok) reg_rdata <= {cur_comp, {(32-CW){1'b0}}};
      lut_rgb <= (lut_idx < LW'(NENT)) ? tbl[lut_idx] : '0;
    end
  end
endmodule

// File: rtl/cmap_dac_chk.sv
module cmap_dac_chk #(
  parameter int ADDR_W = 4,
  parameter int IW     = 8,
  parameter int LW     = 9,
  parameter int NENT   = 260,
  parameter int RGBW   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_be,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [LW-1:0]     lut_idx,
  input logic [RGBW-1:0]   lut_rgb,
  input logic [IW-1:0]     idx,
  input logic [1:0]        phase
);
  wire full = (reg_be == 4'hF);
  wire known = (reg_addr == ADDR_W'(0)) || (reg_addr == ADDR_W'(4)) || (reg_addr == ADDR_W'(12));

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && full && reg_addr == ADDR_W'(0) |=> idx == $past(reg_wdata[31 -: IW]) && phase == 2'd0);

  // R2
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) phase != 2'd3);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && full && reg_addr == ADDR_W'(4) && phase == 2'd2 |=> idx == $past(idx) + 1'b1 && phase == 2'd0);

  // R5
  rdata_low_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[31-IW:0] == '0);

  // R6
  ignored_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (!full || !known) |=> $stable(idx) && $stable(phase));

  // R8
  lut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lut_idx >= LW'(NENT) |=> lut_rgb == '0);
endmodule

bind cmap_dac cmap_dac_chk #(
  .ADDR_W(ADDR_W), .IW(IW), .LW(LW), .NENT(NENT), .RGBW(3*CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .lut_idx(lut_idx), .lut_rgb(lut_rgb), .idx(idx), .phase(phase)
);

// File: tb/cmap_dac_tb.sv
module cmap_dac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_be = 4'hF;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmap_dac u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  localparam logic [1:0] W = 2'd0, RD = 2'd1, LK = 2'd2;
  localparam int NV = 32;
  localparam logic [69:0] VEC [NV] = '{
    {W,  4'd0,  32'h05000000, 32'h0},
    {W,  4'd4,  32'h11000000, 32'h0},
    {W,  4'd4,  32'h22000000, 32'h0},
    {W,  4'd4,  32'h33000000, 32'h0},
    {LK, 4'd0,  32'd5,        32'h00112233},
    {W,  4'd4,  32'h44000000, 32'h0},
    {W,  4'd4,  32'h55000000, 32'h0},
    {W,  4'd4,  32'h66000000, 32'h0},
    {LK, 4'd0,  32'd6,        32'h00445566},
    {W,  4'd0,  32'h05000000, 32'h0},
    {RD, 4'd0,  32'h0,        32'h11000000},
    {RD, 4'd0,  32'h0,        32'h22000000},
    {RD, 4'd0,  32'h0,        32'h33000000},
    {RD, 4'd0,  32'h0,        32'h44000000},
    {W,  4'd0,  32'hFF000000, 32'h0},
    {W,  4'd12, 32'hAA000000, 32'h0},
    {W,  4'd12, 32'hBB000000, 32'h0},
    {W,  4'd12, 32'hCC000000, 32'h0},
    {LK, 4'd0,  32'h103,      32'h00AABBCC},
    {LK, 4'd0,  32'd255,      32'h00FFFFFF},
    {W,  4'd4,  32'h01000000, 32'h0},
    {W,  4'd4,  32'h02000000, 32'h0},
    {W,  4'd4,  32'h03000000, 32'h0},
    {LK, 4'd0,  32'd0,        32'h00010203},
    {W,  4'd8,  32'h77000000, 32'h0},
    {W,  4'd4,  32'h09000000, 32'h0},
    {LK, 4'd0,  32'd1,        32'h00090000},
    {W,  4'd0,  32'h02000000, 32'h0},
    {W,  4'd12, 32'h10000000, 32'h0},
    {LK, 4'd0,  32'h102,      32'h0010FFFF},
    {LK, 4'd0,  32'd2,        32'h00000000},
    {LK, 4'd0,  32'h150,      32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    @(negedge clk);
    reg_be = be;
    case (op)
      W:  begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
      RD: begin reg_rd = 1'b1; reg_addr = a; end
      default: lut_idx = d[8:0];
    endcase
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_be = 4'hF;
  endtask

  task automatic look(input string tag, input logic [8:0] e, input logic [23:0] exp);
    access(LK, 4'd0, 32'(e), 4'hF);
    chk(tag, 32'(lut_rgb), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R7 rdata reset", reg_rdata, 32'h0);
    look("R7 entry255", 9'd255, 24'hFFFFFF);
    look("R7 entry256", 9'd256, 24'hFFFFFF);
    look("R7 entry257", 9'd257, 24'h000000);
    look("R7 entry258", 9'd258, 24'hFFFFFF);
    look("R7 entry259", 9'd259, 24'h000000);
    look("R7 entry0",   9'd0,   24'h000000);
    look("R7 entry100", 9'd100, 24'h000000);
    access(RD, 4'd4, 32'h0, 4'hF);
    chk("R7 R5 read entry0 red", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      access(op, a, d, 4'hF);
      if (op == RD) chk($sformatf("R5 R3 vec%0d", i), reg_rdata, e);
      if (op == LK) chk($sformatf("R1 R2 R3 R4 R6 R8 vec%0d", i), 32'(lut_rgb), e);
    end

    access(W, 4'd0, 32'h0A000000, 4'hF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h80000000; lut_idx = 9'd10;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    chk("R9 same-cycle old value", 32'(lut_rgb), 32'h0);
    @(posedge clk); #1;
    chk("R9 new value next", 32'(lut_rgb), 32'h00800000);

    access(W, 4'd0, 32'h30000000, 4'h7);
    access(W, 4'd4, 32'h66000000, 4'hF);
    look("R6 partial index write ignored", 9'd10, 24'h806600);
    look("R6 entry48 untouched", 9'd48, 24'h000000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule